// File: doc/BRIEF.md
# Bit-Stuffed Frame Receiver with Station Address Filter

This block receives a bit-oriented synchronous line that uses flag-delimited, zero-stuffed framing. A one-cycle strobe marks each receive-clock edge where a line bit is sampled. The block searches the line for the flag pattern 0x7E and pulses a sync output each time it sees one. Inside a frame it removes the zero that the sender inserts after every five consecutive ones. Each frame is checked against a 16-bit frame check sequence.

The first byte of a frame is treated as an address. When filtering is enabled, a frame whose address is neither the programmed station address nor the all-ones broadcast value is dropped without any output. Accepted frames produce their address byte and then characters of a programmable width, from 1 to 8 bits. The last 16 bits before the closing flag are kept back as the check field. At the closing flag the block reports end of frame together with a CRC error flag. A run of seven ones aborts the frame. The start of an abort and the first zero that ends it each raise their own event.

Top module: `hdlc_frame_rx`

## Requirements
- R1: A line pattern of one zero, six ones and one zero (0x7E) produces a one-cycle `syncPulse` in the cycle after the sampling of its final zero. This applies both while hunting and inside a frame.
- R2: Inside a frame, a zero that follows five consecutive ones is removed. Payload bytes 0x7E and 0xFF, sent stuffed, come out unchanged.
- R3: With `addrFilterEn`=1, a frame is accepted only if its first 8 bits (LSB first) equal `stationAddr` or 0xFF. For any other frame, neither `dataValid` nor `eofValid` is raised.
- R4: With `addrFilterEn`=0, every frame is accepted whatever its first byte.
- R5: Bits are taken LSB first. The first character of a frame is always 8 bits. Later characters are `charLenSel` bits wide, where a value of 0 means 8. Each character appears right-aligned on `dataOut` with a one-cycle `dataValid`.
- R6: The last 16 destuffed bits before the closing flag are never delivered as data. The check runs CRC-CCITT, reflected (0x8408), preset to 0xFFFF, over the data and the check field together. A good frame ends with residue 0xF0B8 and gives `eofValid`=1 with `crcErr`=0.
- R7: A frame whose residue differs from 0xF0B8 gives `eofValid`=1 with `crcErr`=1.
- R8: A frame of fewer than 32 destuffed bits between flags gives no `eofValid`. A frame of exactly 32 bits gives one.
- R9: The seventh consecutive one gives a one-cycle `abortStart`. The frame in progress is then dropped without `eofValid`, and the receiver goes back to hunting for a flag.
- R10: The first zero after seven or more ones gives a one-cycle `abortEnd`.
- R11: After reset, every event output is low.
- R12: Cycles with `bitEn` low change no state. Every output event comes exactly one clock after the `bitEn` cycle that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Line bit is sampled in this cycle |
| rxBit | input | 1 | Serial line data |
| stationAddr | input | 8 | Station address to accept |
| addrFilterEn | input | 1 | Enables the first-byte address filter |
| charLenSel | input | 3 | Character width after the address; 0 means 8 |
| syncPulse | output | 1 | Flag recognised |
| dataValid | output | 1 | Character strobe |
| dataOut | output | 8 | Received character, right-aligned |
| eofValid | output | 1 | Accepted frame closed |
| crcErr | output | 1 | Check failed; valid with eofValid |
| abortStart | output | 1 | Seventh consecutive one seen |
| abortEnd | output | 1 | First zero after an abort run |

## Verification
The bench builds the block with its defaults: 8-bit characters, a 16-bit check field, a 6-bit flag lag and a 32-bit minimum frame. These values put the 24-bit and 32-bit frame lengths on either side of the minimum-length boundary within reach. They also make it possible to hit a 3-bit character width that does not divide the payload evenly, and to hit payload bytes that force stuffing. A sparse-strobe run, with two idle clocks between line bits, exercises the one-clock output latency while `bitEn` is low.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD      = 16'hF0B8;

  // Strobes from the line decoder to the frame datapath
  typedef struct packed {
    logic push;        // destuffed in-frame bit available
    logic pushBit;     // its value
    logic flagHit;     // flag completed on this bit
    logic closeFrame;  // that flag ends a frame that was open
  } rxStrobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic inBit);
    logic fb;
    fb = cur[0] ^ inBit;
    crcStep = (cur >> 1) ^ (fb ? CRC_POLY_REFL : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int FLAG_RUN  = 6,
  parameter int ABORT_RUN = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxBit,
  output rxStrobe_t  strobe,
  output logic       syncPulse,
  output logic       abortStart,
  output logic       abortEnd
);

  localparam int OW = $clog2(ABORT_RUN + 1);
  localparam logic [OW-1:0] STUFF_N = OW'(STUFF_RUN);
  localparam logic [OW-1:0] FLAG_N  = OW'(FLAG_RUN);
  localparam logic [OW-1:0] ABORT_N = OW'(ABORT_RUN);

  typedef enum logic {HUNT, INFRAME} lineState_t;

  lineState_t lineState, nextState;
  logic [OW-1:0] onesRun, nextOnes;
  logic evSync, evAbortOn, evAbortOff;

  always_comb begin
    strobe     = '0;
    nextState  = lineState;
    nextOnes   = onesRun;
    evSync     = 1'b0;
    evAbortOn  = 1'b0;
    evAbortOff = 1'b0;
    if (bitEn) begin
      if (rxBit) begin
        nextOnes = (onesRun == ABORT_N) ? onesRun : onesRun + 1'b1;
        if (onesRun == ABORT_N - 1'b1) begin
          evAbortOn = 1'b1;
          nextState = HUNT;
        end
        if (lineState == INFRAME && onesRun < STUFF_N) begin
          strobe.push    = 1'b1;
          strobe.pushBit = 1'b1;
        end
      end else begin
        nextOnes = '0;
        if (onesRun == FLAG_N) begin
          evSync            = 1'b1;
          strobe.flagHit    = 1'b1;
          strobe.closeFrame = (lineState == INFRAME);
          nextState         = INFRAME;
        end else if (onesRun >= ABORT_N) begin
          evAbortOff = 1'b1;
        end else if (onesRun != STUFF_N && lineState == INFRAME) begin
          strobe.push    = 1'b1;
          strobe.pushBit = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineState  <= HUNT;
      onesRun    <= '0;
      syncPulse  <= 1'b0;
      abortStart <= 1'b0;
      abortEnd   <= 1'b0;
    end else begin
      lineState  <= nextState;
      onesRun    <= nextOnes;
      syncPulse  <= evSync;
      abortStart <= evAbortOn;
      abortEnd   <= evAbortOff;
    end
  end

  // R10 / R1: line events are distinct patterns and never share a cycle
  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({syncPulse, abortStart, abortEnd}))
    else $error("line events overlap");

  // R1: a flag needs at least seven line bits, so sync cannot repeat next cycle
  a_r1_sync_spacing: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse)
    else $error("sync pulse repeated back to back");

endmodule

// File: rtl/hdlc_rx_dpath.sv
module hdlc_rx_dpath
  import hdlc_rx_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int FCS_W    = 16,
  parameter int FLAG_LAG = 6,
  parameter int MIN_BITS = 32,
  parameter logic [CHAR_W-1:0] BCAST_ADDR = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rxStrobe_t                 strobe,
  input  logic [CHAR_W-1:0]         stationAddr,
  input  logic                      addrFilterEn,
  input  logic [$clog2(CHAR_W)-1:0] charLenSel,
  output logic                      dataValid,
  output logic [CHAR_W-1:0]         dataOut,
  output logic                      eofValid,
  output logic                      crcErr
);

  localparam int WIN     = FLAG_LAG + FCS_W;
  localparam int EOF_MIN = FLAG_LAG + MIN_BITS;
  localparam int CW      = $clog2(EOF_MIN + 1);
  localparam int BW      = $clog2(CHAR_W + 1);
  localparam logic [CW-1:0] LAG_N  = CW'(FLAG_LAG);
  localparam logic [CW-1:0] WIN_N  = CW'(WIN);
  localparam logic [CW-1:0] MIN_N  = CW'(EOF_MIN);
  localparam logic [BW-1:0] FULL_N = BW'(CHAR_W);

  logic [WIN-1:0]    lagWin;
  logic [CW-1:0]     pushCnt;
  logic [15:0]       crcReg;
  logic [CHAR_W-1:0] chr;
  logic [BW-1:0]     bitCnt;
  logic              addrDone;
  logic              dropped;

  logic [BW-1:0]     target;
  logic [CHAR_W-1:0] chrNext, charVal;
  logic              outBitLive, charDone, addrReject;

  always_comb begin
    if (!addrDone || charLenSel == '0) target = FULL_N;
    else                               target = BW'(charLenSel);
    outBitLive = strobe.push && (pushCnt >= WIN_N);
    chrNext    = {lagWin[WIN-1], chr[CHAR_W-1:1]};
    charDone   = outBitLive && (bitCnt + 1'b1 == target);
    charVal    = chrNext >> (FULL_N - target);
    addrReject = !addrDone && addrFilterEn &&
                 (charVal != stationAddr) && (charVal != BCAST_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lagWin    <= '0;
      pushCnt   <= '0;
      crcReg    <= CRC_PRESET;
      chr       <= '0;
      bitCnt    <= '0;
      addrDone  <= 1'b0;
      dropped   <= 1'b0;
      dataValid <= 1'b0;
      dataOut   <= '0;
      eofValid  <= 1'b0;
      crcErr    <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      eofValid  <= 1'b0;
      crcErr    <= 1'b0;
      if (strobe.flagHit) begin
        if (strobe.closeFrame && pushCnt >= MIN_N && !dropped) begin
          eofValid <= 1'b1;
          crcErr   <= (crcReg != CRC_GOOD);
        end
        pushCnt  <= '0;
        crcReg   <= CRC_PRESET;
        chr      <= '0;
        bitCnt   <= '0;
        addrDone <= 1'b0;
        dropped  <= 1'b0;
      end else if (strobe.push) begin
        if (pushCnt >= LAG_N) crcReg <= crcStep(crcReg, lagWin[FLAG_LAG-1]);
        if (outBitLive) begin
          chr <= chrNext;
          if (charDone) begin
            bitCnt   <= '0;
            addrDone <= 1'b1;
            if (addrReject) begin
              dropped <= 1'b1;
            end else if (!dropped) begin
              dataValid <= 1'b1;
              dataOut   <= charVal;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        lagWin <= {lagWin[WIN-2:0], strobe.pushBit};
        if (pushCnt != '1) pushCnt <= pushCnt + 1'b1;
      end
    end
  end

  // R3: a frame rejected on its address stays silent
  a_r3_drop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    dropped |-> !dataValid)
    else $error("character delivered from a dropped frame");

  a_r3_drop_no_eof: assert property (@(posedge clk) disable iff (!rstN)
    eofValid |-> !$past(dropped))
    else $error("end of frame reported for a dropped frame");

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int FCS_W    = 16,
  parameter int FLAG_LAG = 6,
  parameter int MIN_BITS = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      bitEn,
  input  logic                      rxBit,
  input  logic [CHAR_W-1:0]         stationAddr,
  input  logic                      addrFilterEn,
  input  logic [$clog2(CHAR_W)-1:0] charLenSel,
  output logic                      syncPulse,
  output logic                      dataValid,
  output logic [CHAR_W-1:0]         dataOut,
  output logic                      eofValid,
  output logic                      crcErr,
  output logic                      abortStart,
  output logic                      abortEnd
);

  rxStrobe_t strobe;

  hdlc_rx_ctrl #(
    .STUFF_RUN (FLAG_LAG - 1),
    .FLAG_RUN  (FLAG_LAG),
    .ABORT_RUN (FLAG_LAG + 1)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .rxBit      (rxBit),
    .strobe     (strobe),
    .syncPulse  (syncPulse),
    .abortStart (abortStart),
    .abortEnd   (abortEnd)
  );

  hdlc_rx_dpath #(
    .CHAR_W   (CHAR_W),
    .FCS_W    (FCS_W),
    .FLAG_LAG (FLAG_LAG),
    .MIN_BITS (MIN_BITS)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .stationAddr  (stationAddr),
    .addrFilterEn (addrFilterEn),
    .charLenSel   (charLenSel),
    .dataValid    (dataValid),
    .dataOut      (dataOut),
    .eofValid     (eofValid),
    .crcErr       (crcErr)
  );

  // R6: an end of frame is always reported together with its closing flag
  a_r6_eof_on_flag: assert property (@(posedge clk) disable iff (!rstN)
    eofValid |-> syncPulse)
    else $error("end of frame without a flag");

  // R12: a closing flag carries no data bit, so no character shares its cycle
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !eofValid)
    else $error("character and end of frame in the same cycle");

endmodule

// File: tb/hdlc_frame_rx_bench.sv
module hdlc_frame_rx_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b1;
  logic [7:0] stationAddr = 8'h5A;
  logic       addrFilterEn = 1'b1;
  logic [2:0] charLenSel = 3'd0;
  logic       syncPulse, dataValid, eofValid, crcErr, abortStart, abortEnd;
  logic [7:0] dataOut;

  hdlc_frame_rx u_hdlc_frame_rx (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit),
    .stationAddr(stationAddr), .addrFilterEn(addrFilterEn), .charLenSel(charLenSel),
    .syncPulse(syncPulse), .dataValid(dataValid), .dataOut(dataOut),
    .eofValid(eofValid), .crcErr(crcErr), .abortStart(abortStart), .abortEnd(abortEnd)
  );

  int cmpCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  // expected outputs for the coming negedge
  bit eSync, eDv, eEof, eCrc, eAbS, eAbE;
  logic [7:0] eData;

  // behavioural reference state
  int ones = 0;
  bit inFrame = 0;
  bit q[$];
  logic [7:0] chrVal;
  int chrBits = 0;
  bit addrSeen = 0, drop = 0;

  // observed events
  byte unsigned rxq[$];
  int eofCnt = 0, abSCnt = 0, abECnt = 0;
  bit lastCrc = 0;
  int gap = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    cmpCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcBits(input bit bs[$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      bit fb = c[0] ^ bs[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic compareOut();
    chk(syncPulse === eSync, "R1 syncPulse", syncPulse, eSync);
    chk(dataValid === eDv, "R5 dataValid", dataValid, eDv);
    if (eDv) chk(dataOut === eData, "R5 dataOut", dataOut, eData);
    chk(eofValid === eEof, "R6 eofValid", eofValid, eEof);
    if (eEof) chk(crcErr === eCrc, "R7 crcErr", crcErr, eCrc);
    chk(abortStart === eAbS, "R9 abortStart", abortStart, eAbS);
    chk(abortEnd === eAbE, "R10 abortEnd", abortEnd, eAbE);
    if (dataValid === 1'b1) rxq.push_back(dataOut);
    if (eofValid === 1'b1) begin eofCnt++; lastCrc = crcErr; end
    if (abortStart === 1'b1) abSCnt++;
    if (abortEnd === 1'b1) abECnt++;
  endtask

  task automatic modelPush(input bit b);
    int tgt;
    q.push_back(b);
    if (q.size() > 22) begin
      chrVal[chrBits] = q[q.size() - 23];
      chrBits++;
      tgt = !addrSeen ? 8 : (charLenSel == 0 ? 8 : int'(charLenSel));
      if (chrBits == tgt) begin
        if (!addrSeen) begin
          addrSeen = 1;
          if (addrFilterEn && chrVal != stationAddr && chrVal != 8'hFF) drop = 1;
        end
        if (!drop) begin eDv = 1; eData = chrVal; end
        chrVal = '0;
        chrBits = 0;
      end
    end
  endtask

  task automatic modelStep(input bit b);
    if (b) begin
      ones++;
      if (ones == 7) begin eAbS = 1; inFrame = 0; end
      if (inFrame && ones <= 5) modelPush(1);
    end else begin
      if (ones == 6) begin
        eSync = 1;
        if (inFrame && q.size() >= 38 && !drop) begin
          eEof = 1;
          eCrc = (crcBits(q, q.size() - 6) != 16'hF0B8);
        end
        inFrame = 1;
        q.delete();
        chrVal = '0; chrBits = 0; addrSeen = 0; drop = 0;
      end else if (ones >= 7) begin
        eAbE = 1;
      end else if (ones != 5 && inFrame) begin
        modelPush(0);
      end
      ones = 0;
    end
  endtask

  task automatic tick(input bit en, input bit b);
    @(negedge clk);
    compareOut();
    eSync = 0; eDv = 0; eEof = 0; eCrc = 0; eAbS = 0; eAbE = 0;
    bitEn = en;
    rxBit = b;
    if (en && rstN) modelStep(b);
  endtask

  task automatic sendBit(input bit b);
    tick(1, b);
    repeat (gap) tick(0, 1);
  endtask

  task automatic sendFlag();
    sendBit(0);
    repeat (6) sendBit(1);
    sendBit(0);
  endtask

  task automatic sendStuffed(input bit bs[$]);
    int run = 0;
    foreach (bs[i]) begin
      sendBit(bs[i]);
      if (bs[i]) begin
        run++;
        if (run == 5) begin sendBit(0); run = 0; end
      end else run = 0;
    end
  endtask

  task automatic sendFrame(input byte unsigned bytes[$], input int flipIdx);
    bit bs[$];
    logic [15:0] fcs;
    foreach (bytes[i]) for (int k = 0; k < 8; k++) bs.push_back(bytes[i][k]);
    fcs = ~crcBits(bs, bs.size());
    for (int k = 0; k < 16; k++) bs.push_back(fcs[k]);
    if (flipIdx >= 0) bs[flipIdx] = ~bs[flipIdx];
    sendFlag();
    sendStuffed(bs);
    sendFlag();
    repeat (2) tick(0, 1);
  endtask

  task automatic clearObs();
    rxq.delete(); eofCnt = 0; abSCnt = 0; abECnt = 0; lastCrc = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    summary();
  end

  initial begin
    bit pb[$];
    repeat (4) tick(0, 1);
    rstN = 1'b1;
    tick(0, 1);
    // R11: quiet outputs after reset
    chk(!syncPulse && !dataValid && !eofValid && !abortStart && !abortEnd,
        "R11 outputs after reset", {syncPulse, dataValid, eofValid, abortStart, abortEnd}, 0);

    // R9 / R10: idle marking line then a zero
    clearObs();
    repeat (10) sendBit(1);
    sendBit(0);
    tick(0, 1);
    chk(abSCnt == 1, "R9 abort start on idle ones", abSCnt, 1);
    chk(abECnt == 1, "R10 abort end on first zero", abECnt, 1);

    // R2 / R6: stuffing-heavy payload, matching address
    clearObs();
    sendFrame('{8'h5A, 8'h12, 8'h7E, 8'hFF, 8'h3C}, -1);
    chk(rxq.size() == 5, "R2 character count", rxq.size(), 5);
    if (rxq.size() == 5) begin
      chk(rxq[2] == 8'h7E, "R2 byte 0x7E destuffed", rxq[2], 8'h7E);
      chk(rxq[3] == 8'hFF, "R2 byte 0xFF destuffed", rxq[3], 8'hFF);
      chk(rxq[4] == 8'h3C, "R6 last data byte before FCS", rxq[4], 8'h3C);
    end
    chk(eofCnt == 1 && lastCrc == 0, "R6 good frame", {eofCnt[7:0], 7'd0, lastCrc}, 16'h0100);

    // R3: broadcast accepted
    clearObs();
    sendFrame('{8'hFF, 8'hA5, 8'h01}, -1);
    chk(eofCnt == 1 && rxq.size() == 3, "R3 broadcast accepted", eofCnt, 1);

    // R3: foreign address dropped
    clearObs();
    sendFrame('{8'h33, 8'hA5, 8'h01}, -1);
    chk(rxq.size() == 0, "R3 foreign frame data", rxq.size(), 0);
    chk(eofCnt == 0, "R3 foreign frame eof", eofCnt, 0);

    // R4: filter off
    clearObs();
    addrFilterEn = 1'b0;
    sendFrame('{8'h33, 8'hA5, 8'h01}, -1);
    chk(eofCnt == 1 && rxq.size() == 3, "R4 unfiltered frame", eofCnt, 1);
    addrFilterEn = 1'b1;

    // R7: corrupted bit
    clearObs();
    sendFrame('{8'h5A, 8'h11, 8'h22}, 12);
    chk(eofCnt == 1 && lastCrc == 1, "R7 corrupted frame", lastCrc, 1);

    // R5: 3-bit characters after the address
    clearObs();
    charLenSel = 3'd3;
    sendFrame('{8'h5A, 8'hC6, 8'h5B, 8'h3F}, -1);
    chk(rxq.size() == 9, "R5 3-bit character count", rxq.size(), 9);
    if (rxq.size() == 9) begin
      chk(rxq[0] == 8'h5A, "R5 address stays 8 bits", rxq[0], 8'h5A);
      chk(rxq[1] == 8'h06, "R5 first 3-bit character", rxq[1], 8'h06);
    end
    charLenSel = 3'd0;

    // R8: 24-bit frame is too short, 32-bit frame is enough
    clearObs();
    sendFrame('{8'h5A}, -1);
    chk(eofCnt == 0, "R8 short frame", eofCnt, 0);
    clearObs();
    sendFrame('{8'h5A, 8'h77}, -1);
    chk(eofCnt == 1 && lastCrc == 0, "R8 32-bit frame", eofCnt, 1);

    // R9 / R10: abort inside a frame, then recovery
    clearObs();
    sendFlag();
    pb = '{0,1,0,1,1,0,1,0, 1,0,0,1,0,1,1,0};
    sendStuffed(pb);
    repeat (7) sendBit(1);
    sendBit(0);
    repeat (2) tick(0, 1);
    chk(abSCnt == 1 && abECnt == 1, "R10 abort events in frame", abSCnt + abECnt, 2);
    chk(eofCnt == 0, "R9 aborted frame has no eof", eofCnt, 0);
    sendFrame('{8'h5A, 8'h44}, -1);
    chk(eofCnt == 1 && lastCrc == 0, "R9 recovery after abort", eofCnt, 1);

    // R12: sparse bit strobes
    clearObs();
    gap = 2;
    sendFrame('{8'h5A, 8'h9C, 8'hE1}, -1);
    gap = 0;
    chk(eofCnt == 1 && lastCrc == 0 && rxq.size() == 3, "R12 sparse strobe frame", eofCnt, 1);

    repeat (4) tick(0, 1);
    summary();
  end

endmodule